// File: doc/BRIEF.md
# Paged Flash Window Translator

This block sits between a 16-bit CPU address bus and a memory system with a 20-bit extended address space. The extended space is split into 64 pages of 16K bytes each. The block holds a 6-bit page register. It turns each CPU address into an extended address and flags the access as a hit on internal flash or as an external access.

The CPU space is divided into 16K quarters:
- The quarter at 0x8000–0xBFFF is a window onto whichever page the page register selects.
- The quarter at 0x4000–0x7FFF always shows page 0x3E.
- The quarter at 0xC000–0xFFFF always shows page 0x3F.
- The lowest quarter is left to other decoders.

Pages 0x30–0x3F are internal flash. Pages 0x00–0x2F belong to external memory.

Two static controls shape the map. The first is a flash enable. When it is clear, every flash decode falls through to external memory. The second disables only the direct 0x3E mapping in the low fixed window; that page stays reachable through the paged window.

The page register is written in three ways:
- A plain page write.
- A far-call strobe. This loads the new page and, in the same cycle, presents the outgoing page value to be stacked.
- A far-return strobe. This reloads the page register with a value popped from the stack.

Top module: `flash_page_xlate`

## Requirements
- R1: After a synchronous active-low reset, `cur_page` reads 0x00.
- R2: A page write or a far call loads `page_wdata` into `cur_page` on the next clock edge. `save_page` always shows the page value held before that edge, so a far call can push the old page.
- R3: A far return loads `ret_page` into `cur_page` on the next clock edge. It takes priority over a page write or far call in the same cycle.
- R4: For CPU addresses 0x8000–0xBFFF, `ext_addr` = {cur_page[5:0], cpu_addr[13:0]}, whichever of flash or external the access hits.
- R5: In the paged window with flash enabled, pages 0x30–0x3F assert `flash_hit`, and pages 0x00–0x2F assert `ext_hit`.
- R6: With flash enabled and the low-window disable clear, CPU addresses 0x4000–0x7FFF give `flash_hit` and `ext_addr` = {6'h3E, cpu_addr[13:0]}.
- R7: With flash enabled, CPU addresses 0xC000–0xFFFF give `flash_hit` and `ext_addr` = {6'h3F, cpu_addr[13:0]}, whatever the low-window disable holds.
- R8: With flash disabled, `flash_hit` is never asserted. The two fixed windows then give `ext_hit` with `ext_addr` = {4'h0, cpu_addr}. The paged window gives `ext_hit` with its paged address. At most one of `flash_hit` and `ext_hit` is ever high.
- R9: With the low-window disable set, 0x4000–0x7FFF gives `ext_hit` with `ext_addr` = {4'h0, cpu_addr}. Page 0x3E still hits flash through the paged window.
- R10: CPU addresses 0x0000–0x3FFF raise neither hit flag, and `ext_addr` = {4'h0, cpu_addr}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| page_wr | input | 1 | Plain page register write |
| far_call | input | 1 | Far-call strobe: push old page, load new page |
| page_wdata | input | 6 | New page value for write or far call |
| far_ret | input | 1 | Far-return strobe: restore popped page |
| ret_page | input | 6 | Page value popped from the stack |
| flash_on | input | 1 | Flash present in the map |
| fixed_lo_dis | input | 1 | Disable direct page 0x3E at 0x4000–0x7FFF |
| ext_addr | output | 20 | Translated extended address |
| flash_hit | output | 1 | Access targets internal flash |
| ext_hit | output | 1 | Access targets external memory |
| cur_page | output | 6 | Current page register value |
| save_page | output | 6 | Page value to push on a far call |

## Verification
The translation is driven with addresses at both ends of each 16K quarter, under every combination of the two controls. This tells a correct quarter boundary apart from an off-by-one decode, and a flag-only fall-through from a wrong address form. The paged window is tried with pages 0x2F and 0x30, which separates the external pages from the flash pages exactly at their border, and with page 0x3E, which shows that the low-window disable leaves the paged path alone. Page register updates are tried with a far call, which shows that the outgoing value is offered before the edge. They are also tried with a far return raised together with a far call, which exposes a wrong priority order.

// File: rtl/flash_page_pkg.sv
// Shared constants for the paged flash window translator.
// Assumes a 16-bit CPU bus split into four 16K quarters.
package flash_page_pkg;
    localparam int CPU_W   = 16;
    localparam int PAGE_W  = 6;
    localparam int OFF_W   = CPU_W - 2;
    localparam int XA_W    = PAGE_W + OFF_W;

    localparam logic [PAGE_W-1:0] PG_FIX_LO    = 6'h3E;
    localparam logic [PAGE_W-1:0] PG_FIX_HI    = 6'h3F;
    localparam logic [PAGE_W-1:0] PG_FLASH_MIN = 6'h30;

    typedef enum logic [1:0] {
        Q_LOW   = 2'b00,
        Q_FIXLO = 2'b01,
        Q_PAGED = 2'b10,
        Q_FIXHI = 2'b11
    } quarter_e;
endpackage

// File: rtl/page_reg.sv
// Page register with plain write, far-call load and far-return restore.
// Assumes the caller supplies the popped value on ret_page with far_ret.
module page_reg
    import flash_page_pkg::*;
#(
    parameter int PW = PAGE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          page_wr,
    input  logic          far_call,
    input  logic [PW-1:0] page_wdata,
    input  logic          far_ret,
    input  logic [PW-1:0] ret_page,
    output logic [PW-1:0] page_q,
    output logic [PW-1:0] save_page
);
    // Register update: restore wins over write or call.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (far_ret)
            page_q <= ret_page;
        else if (page_wr || far_call)
            page_q <= page_wdata;
    end

    // The outgoing page is whatever is held before the edge.
    assign save_page = page_q;

    assert_reset_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> page_q == '0);
    assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((page_wr || far_call) && !far_ret) |=> page_q == $past(page_wdata));
    assert_ret_restore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        far_ret |=> page_q == $past(ret_page));
endmodule

// File: rtl/win_decode.sv
// Combinational CPU-to-extended address translation.
// Assumes page_q is stable for the whole access.
module win_decode
    import flash_page_pkg::*;
#(
    parameter int AW = CPU_W,
    parameter int PW = PAGE_W,
    localparam int OW = AW - 2,
    localparam int XW = PW + OW
) (
    input  logic [AW-1:0] cpu_addr,
    input  logic [PW-1:0] page_q,
    input  logic          flash_on,
    input  logic          fixed_lo_dis,
    output logic [XW-1:0] ext_addr,
    output logic          flash_hit,
    output logic          ext_hit
);
    quarter_e         quarter;
    logic [XW-1:0]    flat_addr;

    assign quarter   = quarter_e'(cpu_addr[AW-1:AW-2]);
    assign flat_addr = {{(XW-AW){1'b0}}, cpu_addr};

    // Pick the target page and the hit class for the current quarter.
    always_comb begin
        ext_addr  = flat_addr;
        flash_hit = 1'b0;
        ext_hit   = 1'b0;
        unique case (quarter)
            Q_LOW: ;
            Q_FIXLO: begin
                if (flash_on && !fixed_lo_dis) begin
                    ext_addr  = {PG_FIX_LO, cpu_addr[OW-1:0]};
                    flash_hit = 1'b1;
                end else
                    ext_hit = 1'b1;
            end
            Q_PAGED: begin
                ext_addr = {page_q, cpu_addr[OW-1:0]};
                if (flash_on && page_q >= PG_FLASH_MIN)
                    flash_hit = 1'b1;
                else
                    ext_hit = 1'b1;
            end
            Q_FIXHI: begin
                if (flash_on) begin
                    ext_addr  = {PG_FIX_HI, cpu_addr[OW-1:0]};
                    flash_hit = 1'b1;
                end else
                    ext_hit = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_page_xlate.sv
// Top: page register plus window decode for the paged flash map.
// Assumes the map controls are quasi-static configuration inputs.
module flash_page_xlate
    import flash_page_pkg::*;
#(
    parameter int AW = CPU_W,
    parameter int PW = PAGE_W,
    localparam int XW = PW + AW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic          page_wr,
    input  logic          far_call,
    input  logic [PW-1:0] page_wdata,
    input  logic          far_ret,
    input  logic [PW-1:0] ret_page,
    input  logic          flash_on,
    input  logic          fixed_lo_dis,
    output logic [XW-1:0] ext_addr,
    output logic          flash_hit,
    output logic          ext_hit,
    output logic [PW-1:0] cur_page,
    output logic [PW-1:0] save_page
);
    logic [PW-1:0] page_q;

    // Holds the selected page and handles call/return traffic.
    page_reg #(.PW(PW)) u_page (
        .clk(clk), .rst_n(rst_n), .page_wr(page_wr), .far_call(far_call),
        .page_wdata(page_wdata), .far_ret(far_ret), .ret_page(ret_page),
        .page_q(page_q), .save_page(save_page)
    );

    // Translates each CPU address against the current page.
    win_decode #(.AW(AW), .PW(PW)) u_dec (
        .cpu_addr(cpu_addr), .page_q(page_q), .flash_on(flash_on),
        .fixed_lo_dis(fixed_lo_dis), .ext_addr(ext_addr),
        .flash_hit(flash_hit), .ext_hit(ext_hit)
    );

    assign cur_page = page_q;

    assert_flash_top_pages_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flash_hit |-> ext_addr[XW-1:XW-2] == 2'b11);
    assert_exclusive_hits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flash_hit, ext_hit}));
    assert_flash_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_on |-> !flash_hit);
    assert_low_nohit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[AW-1:AW-2] == 2'b00 |-> (!flash_hit && !ext_hit));
    assert_paged_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[AW-1:AW-2] == 2'b10 |-> ext_addr[XW-1:XW-PW] == cur_page);
endmodule

// File: tb/flash_page_xlate_tb_top.sv
// Directed bench for the paged flash window translator.
module flash_page_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        page_wr = 1'b0, far_call = 1'b0, far_ret = 1'b0;
    logic [5:0]  page_wdata = '0, ret_page = '0;
    logic        flash_on = 1'b1, fixed_lo_dis = 1'b0;
    logic [19:0] ext_addr;
    logic        flash_hit, ext_hit;
    logic [5:0]  cur_page, save_page;
    int          n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    flash_page_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .page_wr(page_wr),
        .far_call(far_call), .page_wdata(page_wdata), .far_ret(far_ret),
        .ret_page(ret_page), .flash_on(flash_on), .fixed_lo_dis(fixed_lo_dis),
        .ext_addr(ext_addr), .flash_hit(flash_hit), .ext_hit(ext_hit),
        .cur_page(cur_page), .save_page(save_page)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive an address, then check address and both flags.
    task automatic probe(string req, logic [15:0] a, logic [19:0] xa, logic fh, logic eh);
        @(negedge clk);
        cpu_addr = a;
        #1;
        chk(req, {12'h0, ext_addr}, {12'h0, xa});
        chk(req, {30'h0, flash_hit, ext_hit}, {30'h0, fh, eh});
    endtask

    // Load the page register through a plain write.
    task automatic set_page(logic [5:0] p);
        @(negedge clk);
        page_wr = 1'b1; page_wdata = p;
        @(negedge clk);
        page_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", {26'h0, cur_page}, 32'h0);
    endtask

    task automatic t_write_paged();
        set_page(6'h12);
        chk("R2", {26'h0, cur_page}, 32'h12);
        probe("R4 R5", 16'h9234, 20'h49234, 1'b0, 1'b1);
        set_page(6'h2F);
        probe("R5 external top page", 16'h8000, 20'hBC000, 1'b0, 1'b1);
        set_page(6'h30);
        probe("R5 first flash page", 16'hBFFF, 20'hC3FFF, 1'b1, 1'b0);
    endtask

    task automatic t_call_ret();
        set_page(6'h12);
        @(negedge clk);
        far_call = 1'b1; page_wdata = 6'h35;
        #1 chk("R2 save before edge", {26'h0, save_page}, 32'h12);
        @(negedge clk);
        far_call = 1'b0;
        chk("R2 call load", {26'h0, cur_page}, 32'h35);
        probe("R4 R5 call page", 16'hA001, 20'hD6001, 1'b1, 1'b0);
        @(negedge clk);
        far_ret = 1'b1; ret_page = 6'h07; far_call = 1'b1; page_wdata = 6'h20;
        @(negedge clk);
        far_ret = 1'b0; far_call = 1'b0;
        chk("R3 restore priority", {26'h0, cur_page}, 32'h07);
    endtask

    task automatic t_fixed();
        flash_on = 1'b1; fixed_lo_dis = 1'b0;
        probe("R6 lo start", 16'h4000, 20'hF8000, 1'b1, 1'b0);
        probe("R6 lo end", 16'h7FFF, 20'hFBFFF, 1'b1, 1'b0);
        probe("R7 hi start", 16'hC000, 20'hFC000, 1'b1, 1'b0);
        probe("R7 hi end", 16'hFFFF, 20'hFFFFF, 1'b1, 1'b0);
    endtask

    task automatic t_flash_off();
        set_page(6'h3A);
        flash_on = 1'b0;
        probe("R8 lo fixed", 16'h5000, 20'h05000, 1'b0, 1'b1);
        probe("R8 hi fixed", 16'hE123, 20'h0E123, 1'b0, 1'b1);
        probe("R8 paged", 16'h8004, 20'hE8004, 1'b0, 1'b1);
        flash_on = 1'b1;
    endtask

    task automatic t_lo_disable();
        fixed_lo_dis = 1'b1;
        set_page(6'h3E);
        probe("R9 lo off", 16'h4123, 20'h04123, 1'b0, 1'b1);
        probe("R9 hi kept", 16'hC000, 20'hFC000, 1'b1, 1'b0);
        probe("R9 page via window", 16'h8010, 20'hF8010, 1'b1, 1'b0);
        fixed_lo_dis = 1'b0;
    endtask

    task automatic t_low();
        probe("R10 top of low", 16'h3FFF, 20'h03FFF, 1'b0, 1'b0);
        probe("R10 zero", 16'h0000, 20'h00000, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_paged();
        t_call_ret();
        t_fixed();
        t_flash_off();
        t_lo_disable();
        t_low();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule